// File: doc/BRIEF.md
# Aligned Word Memory Access Sequencer

This block sits between a load/store requester and a memory whose data bus is two bytes wide and which only transfers naturally aligned words. A request carries a 16-bit segment, a 16-bit offset, an access size (byte or word), a direction and the data to store. The block forms a 20-bit byte address from segment and offset. It then runs one or two aligned bus cycles and steers bytes between the request and the two bus lanes.

An unaligned word is served by two aligned cycles, each touching a single lane. A byte access picks its lane from the least significant address bit. Each bus cycle is held until the memory raises its ready input. The end of the access is signalled by a one-cycle completion pulse, with any read result presented alongside it.

Top module: `aln_mem_seq`

## Requirements
- R1: The byte address is (segment × 16 + offset) taken modulo 2^20.
- R2: Every bus cycle presents an even address: the byte address with bit 0 cleared (the first cycle).
- R3: A word at an even address takes exactly one bus cycle with lane enables 2'b11. A read returns the bus word unchanged. A write drives data[7:0] on lane 0 (bits 7:0) and data[15:8] on lane 1 (bits 15:8).
- R4: A word at an odd address takes two bus cycles. The first has enables 2'b10 and the second, at the following aligned word, has 2'b01. A read takes result bits 7:0 from lane 1 of the first cycle and result bits 15:8 from lane 0 of the second. A write puts data[7:0] on lane 1 first and data[15:8] on lane 0 second.
- R5: A byte at an even address uses one cycle with enables 2'b01. A read returns {8'h00, lane 0}. A write places data[7:0] on lane 0.
- R6: A byte at an odd address uses one cycle with enables 2'b10. A read returns {8'h00, lane 1}. A write places data[7:0] on lane 1.
- R7: While ready is low during a bus cycle, the request strobe, address, enables, direction and write data stay constant.
- R8: The done output is high for exactly the one cycle after the final accepted bus cycle. The read result is valid then and holds until the next read completes. A write leaves it unchanged.
- R9: A request is accepted only while no access is in progress. A request raised during an access has no effect on that access's bus cycles.
- R10: The second cycle of a split word wraps from the top aligned word (0xFFFFE) to address 0.
- R11: After reset, done and the bus request strobe are low and the read result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_seg | input | 16 | Segment value |
| req_off | input | 16 | Offset value |
| req_wdata | input | 16 | Store data (byte stores use bits 7:0) |
| rd_data | output | 16 | Load result, valid with done |
| done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus cycle active |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | 20 | Aligned byte address of the bus word |
| bus_be | output | 2 | Lane enables, bit 0 = bits 7:0 |
| bus_wdata | output | 16 | Write data on the bus |
| bus_rdata | input | 16 | Read data from memory |
| bus_ready | input | 1 | Memory completes the current cycle |

## Verification
Directed cases cover each of the four size/parity combinations, so a swapped lane, a wrong enable or a missing second cycle shows up on one of them alone. Further directed cases use a segment and offset pair with carries across the shifted nibble, which separates a correct address sum from a concatenation, and a word at 0xFFFFF, which isolates the wrap of the second cycle. Random ready delays stress the hold rule, and a request raised during a busy access shows whether it leaks into that access. Random loads and stores over a small address window then read back overlapping bytes and words, exposing byte-order mistakes in either direction.

// File: rtl/aln_seq_pkg.sv
package aln_seq_pkg;
    localparam int SEG_W      = 16;
    localparam int OFF_W      = 16;
    localparam int SEG_SHIFT  = 4;
    localparam int PA_W       = 20;
    localparam int DW         = 16;
    localparam int LANES      = DW / 8;
    localparam int WA_W       = PA_W - 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic            write;
        logic            word;
        logic [PA_W-1:0] pa;
        logic [DW-1:0]   wdata;
    } seq_req_t;

    function automatic logic [PA_W-1:0] phys_addr(input logic [SEG_W-1:0] seg,
                                                  input logic [OFF_W-1:0] off);
        logic [PA_W-1:0] s, o;
        s = PA_W'({seg, {SEG_SHIFT{1'b0}}});
        o = PA_W'(off);
        return s + o;
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input logic word,
                                                   input logic odd,
                                                   input logic second);
        if (second)          return 2'b01;
        else if (odd)        return 2'b10;
        else if (word)       return 2'b11;
        else                 return 2'b01;
    endfunction
endpackage

// File: rtl/aln_addr_gen.sv
module aln_addr_gen
    import aln_seq_pkg::*;
(
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    input  logic [PA_W-1:0]  pa_q,
    input  logic             second,
    output logic [PA_W-1:0]  pa_new,
    output logic [PA_W-1:0]  bus_addr
);
    logic [WA_W-1:0] word_idx;

    always_comb begin
        pa_new   = phys_addr(seg, off);
        // the next aligned word index wraps naturally in WA_W bits
        word_idx = second ? (pa_q[PA_W-1:1] + WA_W'(1)) : pa_q[PA_W-1:1];
        bus_addr = {word_idx, 1'b0};
    end
endmodule

// File: rtl/aln_lane_steer.sv
module aln_lane_steer
    import aln_seq_pkg::*;
(
    input  logic             active,
    input  logic             word,
    input  logic             odd,
    input  logic             second,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    rdata,
    input  logic [7:0]       low_kept,
    output logic [LANES-1:0] be,
    output logic [DW-1:0]    lane_wdata,
    output logic [DW-1:0]    result
);
    always_comb begin
        be = active ? lane_mask(word, odd, second) : '0;

        if (word && !odd)  lane_wdata = wdata;
        else if (second)   lane_wdata = {wdata[15:8], wdata[15:8]};
        else               lane_wdata = {wdata[7:0],  wdata[7:0]};

        if (word && !odd)  result = rdata;
        else if (word)     result = {rdata[7:0], low_kept};
        else if (odd)      result = {8'h00, rdata[15:8]};
        else               result = {8'h00, rdata[7:0]};
    end

    // r5_/r6_: a byte cycle enables exactly one lane
    always_comb begin
        if (active && !word) begin
            a_byte_onehot_r5: assert ($onehot(be));
        end
    end
endmodule

// File: rtl/aln_ctrl.sv
module aln_ctrl
    import aln_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       bus_ready,
    input  logic       split,
    output seq_state_e state,
    output logic       accept,
    output logic       to_second,
    output logic       finish,
    output logic       done
);
    seq_state_e state_d;
    logic       hs;

    always_comb begin
        accept    = (state == ST_IDLE) && req_valid;
        hs        = (state != ST_IDLE) && bus_ready;
        to_second = hs && (state == ST_FIRST) && split;
        finish    = hs && !to_second;
        state_d   = state;
        if (accept)         state_d = ST_FIRST;
        else if (to_second) state_d = ST_SECOND;
        else if (finish)    state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= state_d;
            done  <= finish;
        end
    end

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_second_only_split_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SECOND) |-> split);

    p_second_after_first_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SECOND) |-> ($past(state) == ST_FIRST) || ($past(state) == ST_SECOND));
endmodule

// File: rtl/aln_mem_seq.sv
module aln_mem_seq
    import aln_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_word,
    input  logic [SEG_W-1:0] req_seg,
    input  logic [OFF_W-1:0] req_off,
    input  logic [DW-1:0]    req_wdata,
    output logic [DW-1:0]    rd_data,
    output logic             done,
    output logic             bus_req,
    output logic             bus_we,
    output logic [PA_W-1:0]  bus_addr,
    output logic [LANES-1:0] bus_be,
    output logic [DW-1:0]    bus_wdata,
    input  logic [DW-1:0]    bus_rdata,
    input  logic             bus_ready
);
    seq_state_e      state;
    seq_req_t        req_q;
    logic            accept, to_second, finish;
    logic            split, second;
    logic [PA_W-1:0] pa_new;
    logic [7:0]      low_kept_q;
    logic [DW-1:0]   result;

    assign split   = req_q.word && req_q.pa[0];
    assign second  = (state == ST_SECOND);
    assign bus_req = (state != ST_IDLE);
    assign bus_we  = bus_req && req_q.write;

    aln_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .bus_ready (bus_ready),
        .split     (split),
        .state     (state),
        .accept    (accept),
        .to_second (to_second),
        .finish    (finish),
        .done      (done)
    );

    aln_addr_gen u_addr (
        .seg      (req_seg),
        .off      (req_off),
        .pa_q     (req_q.pa),
        .second   (second),
        .pa_new   (pa_new),
        .bus_addr (bus_addr)
    );

    aln_lane_steer u_lane (
        .active     (bus_req),
        .word       (req_q.word),
        .odd        (req_q.pa[0]),
        .second     (second),
        .wdata      (req_q.wdata),
        .rdata      (bus_rdata),
        .low_kept   (low_kept_q),
        .be         (bus_be),
        .lane_wdata (bus_wdata),
        .result     (result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q      <= '0;
            low_kept_q <= '0;
            rd_data    <= '0;
        end else begin
            if (accept)
                req_q <= '{write: req_write, word: req_word, pa: pa_new, wdata: req_wdata};
            if (to_second)
                low_kept_q <= bus_rdata[15:8];
            if (finish && !req_q.write)
                rd_data <= result;
        end
    end

    p_hold_wait_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ready) |=> bus_req && $stable(bus_addr) && $stable(bus_be)
                                    && $stable(bus_we) && $stable(bus_wdata));

    p_next_word_r10: assert property (@(posedge clk) disable iff (rst)
        (to_second) |=> (bus_addr == $past(bus_addr) + PA_W'(2)));

    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (rst)
        bus_req |=> $stable(req_q));

    p_even_bus_addr_r2: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> !bus_addr[0]);

    p_read_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(rd_data));
endmodule

// File: tb/sim_aln_mem_seq.sv
`timescale 1ns/1ps
module sim_aln_mem_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_word;
    logic [15:0] req_seg, req_off, req_wdata;
    logic [15:0] rd_data;
    logic        done;
    logic        bus_req, bus_we;
    logic [19:0] bus_addr;
    logic [1:0]  bus_be;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        bus_ready;

    always #2.5 clk = ~clk;

    aln_mem_seq u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_word(req_word), .req_seg(req_seg), .req_off(req_off),
        .req_wdata(req_wdata), .rd_data(rd_data), .done(done),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready)
    );

    int checks = 0;
    int fails  = 0;

    logic [7:0] bus_mem [int];
    logic [7:0] ref_mem [int];

    function automatic logic [7:0] def_byte(input logic [19:0] a);
        return a[7:0] ^ {a[11:8], a[19:16]} ^ 8'h5A;
    endfunction

    function automatic logic [7:0] bus_byte(input logic [19:0] a);
        if (bus_mem.exists(int'(a))) return bus_mem[int'(a)];
        return def_byte(a);
    endfunction

    function automatic logic [7:0] ref_byte(input logic [19:0] a);
        if (ref_mem.exists(int'(a))) return ref_mem[int'(a)];
        return def_byte(a);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // bus monitor and memory model
    int          cyc = 0;
    int          hs_n, hs_cyc;
    logic [19:0] hs_addr [2];
    logic [1:0]  hs_be   [2];
    logic        hs_we   [2];
    logic [15:0] hs_wd   [2];
    logic        w_pend = 1'b0;
    logic [38:0] w_snap;
    logic        hold_bad;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst && bus_req) begin
            if (w_pend && ({bus_addr, bus_be, bus_we, bus_wdata} != w_snap)) hold_bad = 1'b1;
            if (bus_ready) begin
                if (hs_n < 2) begin
                    hs_addr[hs_n] = bus_addr;
                    hs_be[hs_n]   = bus_be;
                    hs_we[hs_n]   = bus_we;
                    hs_wd[hs_n]   = bus_wdata;
                end
                hs_n   = hs_n + 1;
                hs_cyc = cyc;
                if (bus_we) begin
                    if (bus_be[0]) bus_mem[int'(bus_addr)]          = bus_wdata[7:0];
                    if (bus_be[1]) bus_mem[int'(bus_addr + 20'd1)]  = bus_wdata[15:8];
                end
                w_pend = 1'b0;
            end else begin
                w_pend = 1'b1;
                w_snap = {bus_addr, bus_be, bus_we, bus_wdata};
            end
        end else begin
            w_pend = 1'b0;
        end
    end

    always @(negedge clk) begin
        bus_ready = ($urandom % 3) != 0;
        bus_rdata = {bus_byte(bus_addr + 20'd1), bus_byte(bus_addr)};
    end

    task automatic do_op(input logic we, input logic word, input logic [15:0] seg,
                         input logic [15:0] off, input logic [15:0] wd, input logic inject);
        logic [19:0] pa, pa2, a0, a1;
        logic [1:0]  be0, m;
        logic [15:0] exp_rd, prev_rd, ew0, ew1;
        int          ncyc, n;
        string       tg;
        pa   = {seg, 4'h0} + {4'h0, off};
        pa2  = pa + 20'd1;
        a0   = {pa[19:1], 1'b0};
        a1   = a0 + 20'd2;
        ncyc = (word && pa[0]) ? 2 : 1;
        be0  = word ? (pa[0] ? 2'b10 : 2'b11) : (pa[0] ? 2'b10 : 2'b01);
        tg   = word ? (pa[0] ? "R4" : "R3") : (pa[0] ? "R6" : "R5");
        exp_rd = word ? {ref_byte(pa2), ref_byte(pa)} : {8'h00, ref_byte(pa)};
        ew0  = (word && !pa[0]) ? wd : {wd[7:0], wd[7:0]};
        ew1  = {wd[15:8], wd[15:8]};
        prev_rd = rd_data;

        @(negedge clk);
        hs_n = 0; hold_bad = 1'b0;
        req_valid = 1'b1; req_write = we; req_word = word;
        req_seg = seg; req_off = off; req_wdata = wd;
        @(negedge clk);
        if (inject) begin
            req_valid = 1'b1; req_write = ~we; req_word = ~word;
            req_seg = seg ^ 16'h0100; req_off = off + 16'd7; req_wdata = ~wd;
        end else begin
            req_valid = 1'b0;
        end
        n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        if (!done) begin
            chk("R8", "timeout waiting for done", 0, 1);
            return;
        end
        chk(inject ? "R9" : tg, "bus cycle count", hs_n, ncyc);
        chk("R1 R2", "first bus address", hs_addr[0], a0);
        chk(tg, "first lane enables", hs_be[0], be0);
        chk(tg, "bus direction", hs_we[0], we);
        if (ncyc == 2 && hs_n == 2) begin
            chk((a0 == 20'hFFFFE) ? "R10" : "R4", "second bus address", hs_addr[1], a1);
            chk("R4", "second lane enables", hs_be[1], 2'b01);
        end
        chk("R8", "done one cycle after final bus cycle", cyc, hs_cyc);
        chk("R7", "bus held during wait", hold_bad, 0);
        if (we) begin
            m = be0;
            chk(tg, "write lanes first cycle", hs_wd[0] & {{8{m[1]}}, {8{m[0]}}},
                ew0 & {{8{m[1]}}, {8{m[0]}}});
            if (ncyc == 2 && hs_n == 2)
                chk("R4", "write lane second cycle", hs_wd[1][7:0], wd[15:8]);
            chk("R8", "write leaves read result", rd_data, prev_rd);
            ref_mem[int'(pa)] = wd[7:0];
            if (word) ref_mem[int'(pa2)] = wd[15:8];
        end else begin
            chk(inject ? "R9" : tg, "read result", rd_data, exp_rd);
        end
        prev_rd = rd_data;
        @(negedge clk);
        chk("R8", "done is single cycle", done, 0);
        chk("R8", "read result held", rd_data, prev_rd);
    endtask

    initial begin
        #(5 * 150000);
        checks++; fails++;
        $display("FAIL watchdog run did not finish actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_word = 1'b0;
        req_seg = '0; req_off = '0; req_wdata = '0;
        bus_ready = 1'b0; bus_rdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11", "done after reset", done, 0);
        chk("R11", "bus_req after reset", bus_req, 0);
        chk("R11", "rd_data after reset", rd_data, 0);

        // directed size/parity cases
        do_op(1'b1, 1'b1, 16'h0000, 16'h0500, 16'h1234, 1'b0);
        do_op(1'b0, 1'b1, 16'h0000, 16'h0500, 16'h0000, 1'b0);
        do_op(1'b0, 1'b0, 16'h0000, 16'h0500, 16'h0000, 1'b0);
        do_op(1'b0, 1'b0, 16'h0000, 16'h0501, 16'h0000, 1'b0);
        do_op(1'b1, 1'b1, 16'h0000, 16'h0521, 16'hF520, 1'b0);
        do_op(1'b0, 1'b1, 16'h0000, 16'h0521, 16'h0000, 1'b0);
        do_op(1'b0, 1'b1, 16'h0000, 16'h0520, 16'h0000, 1'b0);
        do_op(1'b0, 1'b1, 16'h0000, 16'h0522, 16'h0000, 1'b0);
        do_op(1'b1, 1'b0, 16'h0000, 16'h0530, 16'h00AB, 1'b0);
        do_op(1'b1, 1'b0, 16'h0000, 16'h0531, 16'h00CD, 1'b0);
        do_op(1'b0, 1'b1, 16'h0000, 16'h0530, 16'h0000, 1'b0);
        // R1: carries across the shifted nibble
        do_op(1'b1, 1'b1, 16'h1234, 16'h5678, 16'hBEEF, 1'b0);
        do_op(1'b0, 1'b1, 16'h179B, 16'h0008, 16'h0000, 1'b0);
        // R10: split word at the top of the address space
        do_op(1'b1, 1'b1, 16'hF000, 16'hFFFF, 16'hA55A, 1'b0);
        do_op(1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b0);
        do_op(1'b0, 1'b1, 16'hF000, 16'hFFFF, 16'h0000, 1'b0);
        // R9: request raised while busy
        do_op(1'b0, 1'b1, 16'h0000, 16'h0521, 16'h0000, 1'b1);
        do_op(1'b1, 1'b0, 16'h0000, 16'h0540, 16'h0077, 1'b1);
        do_op(1'b0, 1'b0, 16'h0000, 16'h0540, 16'h0000, 1'b0);

        for (int i = 0; i < 400; i++) begin
            logic [15:0] sg;
            case ($urandom % 3)
                0: sg = 16'h0000;
                1: sg = 16'h0001;
                default: sg = 16'hF000;
            endcase
            do_op(1'($urandom), 1'($urandom), sg,
                  (sg == 16'hF000) ? (16'hFFF0 | 16'($urandom % 16)) : 16'($urandom % 48),
                  16'($urandom), 1'(($urandom % 8) == 0));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule